// File: doc/BRIEF.md
# Pattern Fill DMA Channel

This block is one DMA channel that writes a repeated 64-bit pattern across a memory region. Software programs it through a small register port. The settings are a configuration word, an operation-mode field with its own update address, a destination byte pointer, a byte count and the two 32-bit halves of the pattern. A command and status register starts the channel, stops it, pauses it and restarts it.

While the channel is active it issues one 64-bit beat per accepted handshake on a write port that uses valid and ready. Beats are grouped into bursts, and the burst length comes from a code in the configuration word. Every command is checked against the current channel state. A command that is not legal in that state is dropped and raises a sticky error flag. When the last beat is accepted, the channel pulses `done` and returns to idle.

Top module: `fill_dma_chan`

## Requirements
- R1: After reset the configuration word (address 0) reads 0x4401. That is: protect bit 0 set, mode field [6:4] zero, source burst code [10:8] = 4, destination burst code [14:12] = 4. The command/status register (address 6) reads 0 and `mem_valid` is low.
- R2: A write to address 0 updates the protect bit, the source burst code and the destination burst code, and leaves the mode field unchanged. Only a write to address 1 (bits [2:0]) changes the mode field, and address 1 reads the mode back in [2:0].
- R3: Status bits [1:0] of address 6 read 00 when idle, 01 when active and 10 when paused. The code 11 never appears.
- R4: A write of bit 0 (start) to address 6 while idle makes the channel active at that clock edge, provided the mode is 4 (memory fill) and the byte count is legal. `mem_valid` is high from the next cycle.
- R5: A start is refused if the byte count (address 3) is below MIN_BYTES, above MAX_BYTES, or the mode is not 4. A start is also refused while the channel is not idle. A refused start leaves the state unchanged.
- R6: A fill emits floor(count/8) beats. Beat k carries address dest+8k and data {high word (address 5), low word (address 4)}. A beat moves only on a cycle with `mem_valid` and `mem_ready` both high, and address and data hold while it stalls.
- R7: `mem_last` marks the final beat of each burst. A burst is 2^min(code,MAX_BURST_LOG) beats long, where code is the destination burst code, and the final burst of a fill is shortened to the beats that remain.
- R8: `done` is high for exactly one cycle, in the cycle after the final beat is accepted, and the status then reads idle.
- R9: Pause (bit 2) is legal only while active. It drops `mem_valid` and freezes the position. Restart (bit 3) is legal only while paused, and the fill resumes at the next unsent beat.
- R10: Stop (bit 1) while active aborts the fill: the channel goes idle, sends no more beats and gives no `done` pulse. Stop while idle is accepted with no effect and no error. Stop while paused is illegal.
- R11: An illegal command is ignored and sets the sticky error bit 4 of address 6. Writing bit 7 to address 6 clears it. Command priority is stop, pause, restart, start.
- R12: While the protect bit is set and the channel is not idle, writes to addresses 0 to 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Beat offered on the write port |
| mem_ready | input | 1 | Write port accepts the beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | 64 | Pattern data of the beat |
| mem_last | output | 1 | Final beat of a burst |
| done | output | 1 | One-cycle completion pulse |

## Verification
A register write or command takes effect at the rising edge where it is presented. Its readback, and the change to `mem_valid`, are visible in the cycle that follows, so the bench drives at the falling edge and reads one falling edge later. A beat is accepted at the rising edge where valid and ready are both high. The bench therefore checks address, data and burst marker in the half cycle before that edge. It expects `done` and idle status at the falling edge right after the edge that accepts the final beat, and `done` low again one cycle later.

// File: rtl/fill_dma_pkg.sv
package fill_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACTIVE = 2'b01,
        ST_PAUSED = 2'b10
    } chan_state_e;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_DEST = 3'd2;
    localparam logic [2:0] A_SIZE = 3'd3;
    localparam logic [2:0] A_PLO  = 3'd4;
    localparam logic [2:0] A_PHI  = 3'd5;
    localparam logic [2:0] A_ACT  = 3'd6;

    localparam logic [2:0] MODE_MEMFILL = 3'd4;

    typedef struct packed {
        logic       protect;
        logic [2:0] mode;
        logic [2:0] src_code;
        logic [2:0] dst_code;
    } cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic pause;
        logic restart;
        logic clr_err;
    } cmd_t;

endpackage

// File: rtl/fill_regs.sv
module fill_regs
    import fill_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    output cfg_t              cfg_o,
    output logic [ADDR_W-1:0] dest_o,
    output logic [SIZE_W-1:0] size_o,
    output logic [63:0]       pattern_o
);

    typedef struct packed {
        cfg_t              cfg;
        logic [ADDR_W-1:0] dest;
        logic [SIZE_W-1:0] size;
        logic [31:0]       plo;
        logic [31:0]       phi;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ok;

    always_comb begin
        r_d   = r_q;
        wr_ok = we && !(r_q.cfg.protect && busy);
        if (wr_ok) begin
            case (addr)
                A_CFG: begin
                    r_d.cfg.protect  = wdata[0];
                    r_d.cfg.src_code = wdata[10:8];
                    r_d.cfg.dst_code = wdata[14:12];
                end
                A_MODE: r_d.cfg.mode = wdata[2:0];
                A_DEST: r_d.dest     = wdata[ADDR_W-1:0];
                A_SIZE: r_d.size     = wdata[SIZE_W-1:0];
                A_PLO:  r_d.plo      = wdata;
                A_PHI:  r_d.phi      = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q              <= '0;
            r_q.cfg.protect  <= 1'b1;
            r_q.cfg.src_code <= 3'd4;
            r_q.cfg.dst_code <= 3'd4;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o     = r_q.cfg;
    assign dest_o    = r_q.dest;
    assign size_o    = r_q.size;
    assign pattern_o = {r_q.phi, r_q.plo};

    AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_MODE) |=> $stable(r_q.cfg.mode)); // R2
    AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.cfg.protect) |=> $stable(r_q.dest) && $stable(r_q.size)); // R12

endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
    import fill_dma_pkg::*;
#(
    parameter int SIZE_W    = 32,
    parameter int MIN_BYTES = 16,
    parameter int MAX_BYTES = 1 << 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  cmd_t              cmd,
    input  logic [2:0]        mode,
    input  logic [SIZE_W-1:0] size,
    input  logic              final_beat,
    output chan_state_e       state_o,
    output logic              err_o,
    output logic              load_o,
    output logic              done_o
);

    typedef struct packed {
        chan_state_e st;
        logic        err;
        logic        done;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  size_ok;
    logic  illegal;
    logic  load;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        illegal  = 1'b0;
        load     = 1'b0;
        size_ok  = (size >= SIZE_W'(MIN_BYTES)) && (size <= SIZE_W'(MAX_BYTES));
        if (final_beat) begin
            s_d.st   = ST_IDLE;
            s_d.done = 1'b1;
        end
        if (cmd_we) begin
            if (cmd.stop) begin
                if (s_q.st == ST_ACTIVE)      s_d.st  = ST_IDLE;
                else if (s_q.st != ST_IDLE)   illegal = 1'b1;
            end else if (cmd.pause) begin
                if (s_q.st == ST_ACTIVE) begin
                    if (!final_beat) s_d.st = ST_PAUSED;
                end else begin
                    illegal = 1'b1;
                end
            end else if (cmd.restart) begin
                if (s_q.st == ST_PAUSED) s_d.st  = ST_ACTIVE;
                else                     illegal = 1'b1;
            end else if (cmd.start) begin
                if (s_q.st == ST_IDLE && size_ok && mode == MODE_MEMFILL) begin
                    s_d.st = ST_ACTIVE;
                    load   = 1'b1;
                end else begin
                    illegal = 1'b1;
                end
            end
        end
        s_d.err = (s_q.err && !(cmd_we && cmd.clr_err)) || illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.err  <= 1'b0;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q.st;
    assign err_o   = s_q.err;
    assign done_o  = s_q.done;
    assign load_o  = load;

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE) || (s_q.st == ST_ACTIVE) || (s_q.st == ST_PAUSED)); // R3
    AST_DONE_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> ($past(s_q.st) == ST_ACTIVE) && (s_q.st == ST_IDLE)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !(cmd_we && cmd.clr_err)) |=> s_q.err); // R11

endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 32,
    parameter int MAX_BURST_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] dest,
    input  logic [SIZE_W-4:0] beats,
    input  logic [2:0]        dst_code,
    input  logic              run,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_last,
    output logic              final_beat
);

    localparam int BEAT_W = SIZE_W - 3;
    localparam int BL_W   = MAX_BURST_LOG + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] remain;
        logic [BL_W-1:0]   left;
        logic [BL_W-1:0]   blen;
    } eng_t;

    eng_t       e_d, e_q;
    logic       fire;
    logic [2:0] eff_code;
    logic [BL_W-1:0] new_blen;

    function automatic logic [BL_W-1:0] clip(input logic [BEAT_W-1:0] rem,
                                             input logic [BL_W-1:0]   bl);
        if (rem < BEAT_W'(bl)) return BL_W'(rem);
        return bl;
    endfunction

    always_comb begin
        e_d      = e_q;
        fire     = run && (e_q.remain != '0) && mem_ready;
        eff_code = (dst_code > 3'(MAX_BURST_LOG)) ? 3'(MAX_BURST_LOG) : dst_code;
        new_blen = BL_W'(1) << eff_code;
        if (load) begin
            e_d.addr   = dest;
            e_d.remain = beats;
            e_d.blen   = new_blen;
            e_d.left   = clip(beats, new_blen);
        end else if (fire) begin
            e_d.addr   = e_q.addr + ADDR_W'(8);
            e_d.remain = e_q.remain - 1'b1;
            if (e_q.left == BL_W'(1)) e_d.left = clip(e_q.remain - 1'b1, e_q.blen);
            else                      e_d.left = e_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign mem_valid  = run && (e_q.remain != '0);
    assign mem_addr   = e_q.addr;
    assign mem_last   = (e_q.left == BL_W'(1));
    assign final_beat = fire && (e_q.remain == BEAT_W'(1));

    AST_LAST_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        final_beat |-> mem_last); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(mem_addr)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> mem_addr == $past(mem_addr) + ADDR_W'(8)); // R6

endmodule

// File: rtl/fill_dma_chan.sv
module fill_dma_chan
    import fill_dma_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 32,
    parameter int MIN_BYTES     = 16,
    parameter int MAX_BYTES     = 1 << 20,
    parameter int MAX_BURST_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_data,
    output logic              mem_last,
    output logic              done
);

    cfg_t              cfg;
    logic [ADDR_W-1:0] dest;
    logic [SIZE_W-1:0] size;
    logic [63:0]       pattern;
    chan_state_e       st;
    logic              err;
    logic              load;
    logic              final_beat;
    logic              busy;
    logic              cmd_we;
    cmd_t              cmd;

    assign busy       = (st != ST_IDLE);
    assign cmd_we     = reg_we && (reg_addr == A_ACT);
    assign cmd.start   = reg_wdata[0];
    assign cmd.stop    = reg_wdata[1];
    assign cmd.pause   = reg_wdata[2];
    assign cmd.restart = reg_wdata[3];
    assign cmd.clr_err = reg_wdata[7];

    fill_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .cfg_o(cfg), .dest_o(dest), .size_o(size), .pattern_o(pattern)
    );

    fill_ctrl #(.SIZE_W(SIZE_W), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd), .mode(cfg.mode),
        .size(size), .final_beat(final_beat), .state_o(st), .err_o(err),
        .load_o(load), .done_o(done)
    );

    fill_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_BURST_LOG(MAX_BURST_LOG)) u_eng (
        .clk(clk), .rst_n(rst_n), .load(load), .dest(dest), .beats(size[SIZE_W-1:3]),
        .dst_code(cfg.dst_code), .run(st == ST_ACTIVE), .mem_ready(mem_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_last(mem_last),
        .final_beat(final_beat)
    );

    assign mem_data = pattern;

    always_comb begin
        case (reg_addr)
            A_CFG:  reg_rdata = {17'b0, cfg.dst_code, 1'b0, cfg.src_code, 1'b0,
                                 cfg.mode, 3'b0, cfg.protect};
            A_MODE: reg_rdata = {29'b0, cfg.mode};
            A_DEST: reg_rdata = 32'(dest);
            A_SIZE: reg_rdata = 32'(size);
            A_PLO:  reg_rdata = pattern[31:0];
            A_PHI:  reg_rdata = pattern[63:32];
            A_ACT:  reg_rdata = {27'b0, err, 2'b0, st};
            default: reg_rdata = 32'b0;
        endcase
    end

    AST_PAUSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAUSED) |-> !mem_valid); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !mem_valid); // R10

endmodule

// File: tb/tb_fill_dma_chan.sv
`timescale 1ns/1ps
module tb_fill_dma_chan;

    localparam int MAXB = 1 << 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [63:0] mem_data;
    logic        mem_last;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fill_dma_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_last(mem_last), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic int exp_blen(input int code);
        return 1 << ((code > 4) ? 4 : code);
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic run_fill(input logic [31:0] dest, input int size, input logic [31:0] hi,
                            input logic [31:0] lo, input int code, input int pct,
                            input int pause_k);
        logic [31:0] v;
        logic [31:0] a0;
        int total = size / 8;
        int bl = exp_blen(code);
        int k = 0;
        int bstart = 0;
        int cur;
        int guard = 0;
        bit paused = 0;
        cur = min2(total, bl);
        wr(3'd0, 32'h0000_0401 | (32'(code) << 12));
        wr(3'd2, dest);
        wr(3'd3, 32'(size));
        wr(3'd4, lo);
        wr(3'd5, hi);
        mem_ready = 1'b0;
        wr(3'd6, 32'h1);
        rd(3'd6, v);
        check("R4 status active after start", v, 32'h1);
        check("R4 valid after start", mem_valid, 1);
        while (k < total && guard < 5000) begin
            guard++;
            if (k == pause_k && !paused) begin
                paused = 1;
                reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h4; mem_ready = 1'b0;
                @(negedge clk);
                reg_we = 1'b0;
                rd(3'd6, v);
                check("R9 paused status", v, 32'h2);
                a0 = mem_addr;
                mem_ready = 1'b1;
                repeat (3) @(negedge clk);
                #1;
                check("R9 no beat while paused", mem_valid, 0);
                check("R9 position frozen", mem_addr, a0);
                reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h8; mem_ready = 1'b0;
                @(negedge clk);
                reg_we = 1'b0;
                rd(3'd6, v);
                check("R9 restart resumes active", v, 32'h1);
            end
            mem_ready = (($urandom % 100) < pct);
            #1;
            if (mem_valid && mem_ready) begin
                check("R6 beat address", mem_addr, dest + 32'(8 * k));
                check("R6 beat data", mem_data, {hi, lo});
                check("R7 burst last", mem_last, (k - bstart == cur - 1));
                if (k - bstart == cur - 1) begin
                    bstart = k + 1;
                    cur = min2(total - bstart, bl);
                end
                k++;
            end
            @(negedge clk);
        end
        mem_ready = 1'b0;
        check("R6 all beats sent", guard < 5000, 1);
        #1;
        check("R8 done pulse", done, 1);
        rd(3'd6, v);
        check("R8 idle after done", v, 32'h0);
        @(negedge clk);
        #1;
        check("R8 done one cycle", done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, v);  check("R1 reset config", v, 32'h4401);
        rd(3'd6, v);  check("R1 reset status", v, 32'h0);
        check("R1 reset valid", mem_valid, 0);

        wr(3'd0, 32'h0000_3270);
        rd(3'd0, v);  check("R2 mode kept on config write", v, 32'h3200);
        wr(3'd1, 32'h4);
        rd(3'd0, v);  check("R2 mode update in config", v, 32'h3240);
        rd(3'd1, v);  check("R2 mode readback", v, 32'h4);

        wr(3'd6, 32'h2);
        rd(3'd6, v);  check("R10 stop while idle no effect", v, 32'h0);
        wr(3'd6, 32'h4);
        rd(3'd6, v);  check("R11 pause while idle sets error", v, 32'h10);
        wr(3'd6, 32'h80);
        rd(3'd6, v);  check("R11 error clear", v, 32'h0);
        wr(3'd6, 32'h8);
        rd(3'd6, v);  check("R11 restart while idle sets error", v, 32'h10);
        wr(3'd6, 32'h80);

        wr(3'd3, 32'd8);
        wr(3'd6, 32'h1);
        rd(3'd6, v);  check("R5 size below min refused", v, 32'h10);
        wr(3'd6, 32'h80);
        wr(3'd3, MAXB + 8);
        wr(3'd6, 32'h1);
        rd(3'd6, v);  check("R5 size above max refused", v, 32'h10);
        wr(3'd6, 32'h80);
        wr(3'd1, 32'h1);
        wr(3'd3, 32'd64);
        wr(3'd6, 32'h1);
        rd(3'd6, v);  check("R5 wrong mode refused", v, 32'h10);
        check("R5 no beat after refusal", mem_valid, 0);
        wr(3'd1, 32'h4);
        wr(3'd6, 32'h80);

        run_fill(32'h0000_1000, 16, 32'hDEAD_BEEF, 32'h0BAD_F00D, 4, 100, -1);
        run_fill(32'h0000_2000, 200, 32'h1234_5678, 32'h9ABC_DEF0, 2, 60, 5);
        for (int i = 0; i < 6; i++) begin
            run_fill($urandom & 32'h00FF_FFF8, (($urandom % 40) + 2) * 8 + ($urandom % 8),
                     $urandom, $urandom, $urandom % 8, 30 + ($urandom % 71), -1);
        end

        wr(3'd0, 32'h0000_4401);
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'd800);
        mem_ready = 1'b0;
        wr(3'd6, 32'h1);
        wr(3'd2, 32'h0000_ABC0);
        rd(3'd2, v);  check("R12 protected write ignored", v, 32'h2000);
        wr(3'd6, 32'h1);
        rd(3'd6, v);  check("R5 start while active refused", v, 32'h11);
        wr(3'd6, 32'h80);
        rd(3'd6, v);  check("R11 clear while active", v, 32'h01);
        wr(3'd6, 32'h8);
        rd(3'd6, v);  check("R11 restart while active illegal", v, 32'h11);
        wr(3'd6, 32'h80);
        wr(3'd6, 32'h4);
        wr(3'd6, 32'h2);
        rd(3'd6, v);  check("R10 stop while paused illegal", v, 32'h12);
        wr(3'd6, 32'h88);
        mem_ready = 1'b1;
        repeat (4) @(negedge clk);
        mem_ready = 1'b0;
        wr(3'd6, 32'h2);
        rd(3'd6, v);  check("R10 stop aborts to idle", v, 32'h0);
        check("R10 no beat after stop", mem_valid, 0);
        mem_ready = 1'b1;
        repeat (3) begin
            @(negedge clk);
            #1;
            check("R10 no done after stop", done, 0);
        end
        check("R10 still silent", mem_valid, 0);
        rd(3'd6, v);  check("R3 status idle code", v[1:0], 2'b00);
        mem_ready = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule